// File: doc/BRIEF.md
# Block-Averaging ADC Sampler with Serial Report

This block takes 10-bit codes from an external parallel-output converter, which is clocked from the same system clock, and accepts one code on each cycle in which the sample-enable input is high. In normal use the enable arrives at a 1 MHz rate. The block sums 300 accepted codes and then divides the sum by 300, rounding to the nearest integer. It presents the quotient as an average current code with a one-cycle valid pulse. Averaging blocks do not overlap: the next block begins with the next accepted code, and no code is dropped while the division runs.

Each new average is also sent on an asynchronous serial line in 8N1 format, as two bytes. The line runs at 9600 baud by default, and the baud rate is derived from the system-clock parameter. The transmitter keeps a single pending slot. When an average arrives while a report is still on the line, it replaces whatever is waiting in that slot, so the line always carries the newest result next.

Top module: `adc_block_averager`

## Requirements
- R1: While reset is low and after it is released, avgOut is 0, avgValid is 0 and txLine stays high.
- R2: Codes are unsigned offset binary, where 0 is the most negative value and 512 is midscale. The reported average is floor((S + 150) / 300), where S is the sum of the 300 accepted codes, so a mean ending in .5 rounds up.
- R3: A cycle with sampleEn low does not affect any result, whatever value sits on sampleIn.
- R4: Blocks are consecutive and disjoint. The 301st accepted code is the first code of the next block.
- R5: avgValid is high for exactly one cycle. It rises on the 19th rising edge after the edge that accepts the 300th code of a block. avgOut holds its value until the next pulse.
- R6: Each serial frame is a low start bit, 8 data bits least significant bit first, and a high stop bit, each bit lasting CLK_HZ/BAUD clocks. The line idles high.
- R7: Each average is sent as two frames back to back. The first frame is {6'b0, avg[9:8]} and the second is avg[7:0].
- R8: An average produced while a report is in progress waits in a single slot. A later average overwrites it, and only the slot's content is sent after the current report.
- R9: Reset in the middle of a block discards the partial sum. The first block after reset contains only codes accepted after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the converter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleEn | input | 1 | High for one cycle per converter sample to accept |
| sampleIn | input | 10 | Offset-binary converter code |
| avgOut | output | 10 | Latest rounded block average |
| avgValid | output | 1 | One-cycle pulse when avgOut is updated |
| txLine | output | 1 | Serial 8N1 output, idle high |

## Verification
The averaging path is driven with constant blocks at zero, full scale and midscale, which separate correct accumulator width and scaling from overflow or truncation. An alternating zero/full-scale block and a unit ramp both have means ending in exactly .5, so they expose a missing or misplaced rounding term. A block with a single non-zero code of 150, and another with 149, sits on the rounding threshold and separates floor from round-to-nearest. Enable gaps that carry junk data show whether idle cycles leak into the sum. Three back-to-back blocks check block boundaries and the overwrite of the pending report, and a reset in the middle of a block checks that the partial sum is discarded.

// File: rtl/adcavg_pkg.sv
package adcavg_pkg;
  // Strobes from the sample-counting control to the averaging datapath.
  typedef struct packed {
    logic sampleTake; // accepted code that is not the last in its block
    logic blockEnd;   // accepted code that closes the block
  } ctrl_strobes_t;
endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
  import adcavg_pkg::*;
#(
  parameter int BLOCK_LEN = 300
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleEn,
  output ctrl_strobes_t strobes
);
  localparam int CNT_W = $clog2(BLOCK_LEN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_LEN - 1);

  logic [CNT_W-1:0] sampleCnt;
  logic             isLast;

  assign isLast = (sampleCnt == LAST_IDX);

  always_comb begin
    strobes.sampleTake = sampleEn && !isLast;
    strobes.blockEnd   = sampleEn && isLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= '0;
    end else if (sampleEn) begin
      sampleCnt <= isLast ? '0 : sampleCnt + 1'b1;
    end
  end

  // R4: the position inside a block never leaves the block
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(sampleCnt) < BLOCK_LEN);

  // R3: an idle enable leaves the block position untouched
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(sampleCnt));
endmodule

// File: rtl/avg_datapath.sv
module avg_datapath
  import adcavg_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int BLOCK_LEN = 300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  ctrl_strobes_t     strobes,
  output logic [DATA_W-1:0] avgOut,
  output logic              avgValid
);
  localparam int HALF    = BLOCK_LEN / 2;
  localparam int MAX_DIV = BLOCK_LEN * ((1 << DATA_W) - 1) + HALF;
  localparam int ACC_W   = $clog2(MAX_DIV + 1);
  localparam int REM_W   = $clog2(BLOCK_LEN) + 1;
  localparam int STEP_W  = $clog2(ACC_W);
  localparam logic [REM_W-1:0]  LEN_R     = REM_W'(BLOCK_LEN);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(ACC_W - 1);

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  divQuot;   // dividend shifts out at the top, quotient enters at the bottom
  logic [REM_W-1:0]  divRem;
  logic [STEP_W-1:0] stepCnt;
  logic              divBusy;
  logic [REM_W-1:0]  trial;
  logic              fits;
  logic [REM_W-1:0]  nextRem;
  logic [ACC_W-1:0]  nextQuot;

  // Accumulator: cleared as the closing code is handed to the divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobes.blockEnd) begin
      acc <= '0;
    end else if (strobes.sampleTake) begin
      acc <= acc + ACC_W'(sampleIn);
    end
  end

  // One restoring-division step per cycle
  always_comb begin
    trial    = {divRem[REM_W-2:0], divQuot[ACC_W-1]};
    fits     = (trial >= LEN_R);
    nextRem  = fits ? trial - LEN_R : trial;
    nextQuot = {divQuot[ACC_W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQuot  <= '0;
      divRem   <= '0;
      stepCnt  <= '0;
      divBusy  <= 1'b0;
      avgOut   <= '0;
      avgValid <= 1'b0;
    end else begin
      avgValid <= 1'b0;
      if (strobes.blockEnd) begin
        divQuot <= acc + ACC_W'(sampleIn) + ACC_W'(HALF);
        divRem  <= '0;
        stepCnt <= '0;
        divBusy <= 1'b1;
      end else if (divBusy) begin
        divQuot <= nextQuot;
        divRem  <= nextRem;
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt == LAST_STEP) begin
          divBusy  <= 1'b0;
          avgOut   <= nextQuot[DATA_W-1:0];
          avgValid <= 1'b1;
        end
      end
    end
  end

  // R5: a result is announced for a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    avgValid |=> !avgValid);

  // R5: the reported average only moves together with its pulse
  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !avgValid |-> $stable(avgOut));

  // R4: a block never closes while the previous quotient is in progress
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    strobes.blockEnd |-> !divBusy);

  // R2: the remainder stays below the divisor during division
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    divBusy |-> (divRem < LEN_R));
endmodule

// File: rtl/avg_uart_tx.sv
module avg_uart_tx #(
  parameter int DATA_W       = 10,
  parameter int CLKS_PER_BIT = 5208
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] avgIn,
  input  logic              avgValid,
  output logic              txLine
);
  localparam int WORD_W = 16;
  localparam int BAUD_W = $clog2(CLKS_PER_BIT);
  localparam logic [BAUD_W-1:0] BAUD_LAST = BAUD_W'(CLKS_PER_BIT - 1);
  localparam logic [3:0]        BIT_LAST  = 4'd9;

  logic [WORD_W-1:0] pendWord;
  logic              pendValid;
  logic              busy;
  logic [9:0]        frame;     // {stop, data[7:0], start}, bit 0 on the line
  logic [7:0]        lowByte;
  logic              onLowByte;
  logic [3:0]        bitCnt;
  logic [BAUD_W-1:0] baudCnt;
  logic              load;

  assign load   = !busy && pendValid;
  assign txLine = frame[0];

  // Single pending slot: newest average wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWord  <= '0;
      pendValid <= 1'b0;
    end else if (avgValid) begin
      pendWord  <= WORD_W'(avgIn);
      pendValid <= 1'b1;
    end else if (load) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      frame     <= '1;
      lowByte   <= '0;
      onLowByte <= 1'b0;
      bitCnt    <= '0;
      baudCnt   <= '0;
    end else if (load) begin
      frame     <= {1'b1, pendWord[15:8], 1'b0};
      lowByte   <= pendWord[7:0];
      onLowByte <= 1'b0;
      bitCnt    <= '0;
      baudCnt   <= '0;
      busy      <= 1'b1;
    end else if (busy) begin
      if (baudCnt == BAUD_LAST) begin
        baudCnt <= '0;
        if (bitCnt == BIT_LAST) begin
          bitCnt <= '0;
          if (!onLowByte) begin
            frame     <= {1'b1, lowByte, 1'b0};
            onLowByte <= 1'b1;
          end else begin
            frame <= '1;
            busy  <= 1'b0;
          end
        end else begin
          frame  <= {1'b1, frame[9:1]};
          bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        baudCnt <= baudCnt + 1'b1;
      end
    end
  end

  // R6: the line rests high whenever no report is in flight
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  // R6: every report opens with a start bit
  a_r6_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txLine);

  // R8: a fresh average always lands in the slot
  a_r8_slot_capture: assert property (@(posedge clk) disable iff (!rstN)
    avgValid |=> (pendValid && pendWord[DATA_W-1:0] == $past(avgIn)));
endmodule

// File: rtl/adc_block_averager.sv
module adc_block_averager
  import adcavg_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int BLOCK_LEN = 300,
  parameter int CLK_HZ    = 50_000_000,
  parameter int BAUD      = 9600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] avgOut,
  output logic              avgValid,
  output logic              txLine
);
  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;

  ctrl_strobes_t strobes;

  avg_ctrl #(.BLOCK_LEN(BLOCK_LEN)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .strobes  (strobes)
  );

  avg_datapath #(.DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .strobes  (strobes),
    .avgOut   (avgOut),
    .avgValid (avgValid)
  );

  avg_uart_tx #(.DATA_W(DATA_W), .CLKS_PER_BIT(CLKS_PER_BIT)) i_uart (
    .clk      (clk),
    .rstN     (rstN),
    .avgIn    (avgOut),
    .avgValid (avgValid),
    .txLine   (txLine)
  );
endmodule

// File: tb/test_adc_block_averager.sv
module test_adc_block_averager;
  localparam int CPB = 40;  // 125 MHz / 3.125 MHz

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleEn = 1'b0;
  logic [9:0] sampleIn = '0;
  logic [9:0] avgOut;
  logic       avgValid;
  logic       txLine;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_block_averager #(
    .DATA_W(10), .BLOCK_LEN(300), .CLK_HZ(125_000_000), .BAUD(3_125_000)
  ) i_adc_block_averager (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .sampleIn(sampleIn),
    .avgOut(avgOut), .avgValid(avgValid), .txLine(txLine)
  );

  // {pattern kind, value, expected average}
  // kind 0: constant; 1: odd index = value, even = 0; 2: value + index; 3: only index 299 = value
  localparam logic [21:0] VECS [0:7] = '{
    {2'd0, 10'd0,    10'd0},
    {2'd0, 10'd1023, 10'd1023},
    {2'd0, 10'd512,  10'd512},
    {2'd1, 10'd1023, 10'd512},
    {2'd2, 10'd0,    10'd150},
    {2'd2, 10'd700,  10'd850},
    {2'd3, 10'd150,  10'd1},
    {2'd3, 10'd149,  10'd0}
  };

  function automatic logic [9:0] patVal(input logic [1:0] kind, input logic [9:0] v, input int i);
    case (kind)
      2'd0:    return v;
      2'd1:    return (i % 2 == 1) ? v : 10'd0;
      2'd2:    return v + 10'(i);
      default: return (i == 299) ? v : 10'd0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic feedBlock(input logic [1:0] kind, input logic [9:0] v, input bit gaps);
    for (int i = 0; i < 300; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        sampleEn = 1'b0;
        sampleIn = 10'h3FF;   // junk while idle (R3)
      end
      @(negedge clk);
      sampleEn = 1'b1;
      sampleIn = patVal(kind, v, i);
    end
  endtask

  task automatic rxByte(output logic [7:0] b, output logic stopBit);
    int guard = 0;
    while (txLine && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (CPB / 2) @(negedge clk);
    check("R6 start bit", int'(txLine), 0);
    for (int k = 0; k < 8; k++) begin
      repeat (CPB) @(negedge clk);
      b[k] = txLine;
    end
    repeat (CPB) @(negedge clk);
    stopBit = txLine;
  endtask

  task automatic rxAverage(input int exp, input string tag);
    logic [7:0] hi, lo;
    logic       s1, s2;
    rxByte(hi, s1);
    rxByte(lo, s2);
    check({tag, " R7 high byte"}, int'(hi), exp >> 8);
    check({tag, " R7 low byte"}, int'(lo), exp & 255);
    check({tag, " R6 stop bits"}, int'({s1, s2}), 3);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int lat;
    int got [3];
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 avgValid in reset", int'(avgValid), 0);
    check("R1 txLine in reset", int'(txLine), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 avgOut after reset", int'(avgOut), 0);
    check("R1 txLine after reset", int'(txLine), 1);

    // Vector table: R2 values, R3 gaps on odd entries, R5 timing, R6/R7 report
    for (int v = 0; v < 8; v++) begin
      feedBlock(VECS[v][21:20], VECS[v][19:10], v % 2 == 1);
      lat = 0;
      do begin
        @(negedge clk);
        sampleEn = 1'b0;
        lat++;
      end while (!avgValid && lat < 100);
      // captured at edge E0; pulse set on edge 19 after it, seen at the 20th negedge
      check($sformatf("R5 latency vec%0d", v), lat, 20);
      check($sformatf("R2 average vec%0d", v), int'(avgOut), int'(VECS[v][9:0]));
      @(negedge clk);
      check($sformatf("R5 pulse width vec%0d", v), int'(avgValid), 0);
      rxAverage(int'(VECS[v][9:0]), $sformatf("vec%0d", v));
      check($sformatf("R5 hold vec%0d", v), int'(avgOut), int'(VECS[v][9:0]));
    end

    // R4 + R8: three back-to-back blocks while the line is busy
    fork
      begin
        feedBlock(2'd0, 10'd100, 1'b0);
        feedBlock(2'd0, 10'd200, 1'b0);
        feedBlock(2'd0, 10'd300, 1'b0);
        @(negedge clk);
        sampleEn = 1'b0;
      end
      begin
        for (int k = 0; k < 3; k++) begin
          int g = 0;
          do begin
            @(negedge clk);
            g++;
          end while (!avgValid && g < 2000);
          got[k] = int'(avgOut);
        end
      end
      begin
        rxAverage(100, "first of burst R8");
        rxAverage(300, "overwritten slot R8");
      end
    join
    check("R4 block 1", got[0], 100);
    check("R4 block 2", got[1], 200);
    check("R4 block 3", got[2], 300);
    repeat (2 * CPB * 12) @(negedge clk);
    check("R8 no third report txLine idle", int'(txLine), 1);

    // R9: reset in the middle of a block
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      sampleEn = 1'b1;
      sampleIn = 10'd1023;
    end
    @(negedge clk);
    sampleEn = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 avgOut cleared by reset", int'(avgOut), 0);
    rstN = 1'b1;
    feedBlock(2'd0, 10'd50, 1'b0);
    lat = 0;
    do begin
      @(negedge clk);
      sampleEn = 1'b0;
      lat++;
    end while (!avgValid && lat < 100);
    check("R9 partial block discarded", int'(avgOut), 50);
    rxAverage(50, "after reset R9");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule